// File: doc/BRIEF.md
# PRBS-7 Parallel Pattern Generator and Checker

This block is a built-in self-test stage for a 10-bit parallel serdes datapath. When the test enable is high, the transmit side drops the user's parallel word. In its place it sends a maximal-length pseudo-random stream with a 127-bit period, ten sequence bits per word clock. The same enable starts a receive-side checker. The checker compares every incoming word against the sequence it predicts and reports the result on an active-high pass flag.

The checker needs no shared seed. It takes its register contents from the first seven received bits after the enable rises, then checks every later bit. A mode input picks how the flag behaves. In transparent mode it follows the result of the last word checked. In sticky mode a single error pulls it low, and it stays low until the test is stopped. An internal loopback feeds transmit words straight into the receiver and drops the external output enable, so the whole loop can be tested on one chip.

With the test enable low, user data passes through unchanged and the flag stays high.

Top module: `prbs7_bist`

## Requirements
- R1: The generator uses the polynomial x^7 + x^6 + 1. Each new bit is the XOR of the bits seven and six places earlier in the stream. The first bit of each word is placed in bit 0. Starting from the all-ones state, the first two words after the enable rises are 0x040 and 0x10C.
- R2: The transmit pattern repeats every 127 bits. Word 127 after the enable rises equals word 0 (0x040).
- R3: While the test enable is high, txWord carries the generated pattern and does not depend on txUserData.
- R4: The checker takes its seed from the first seven bits of the first word received after the enable rises. Only bits 7..9 of that word are checked. pass is low while the enable is high and no word has been checked yet. After the first word's clock edge, pass gives that word's result.
- R5: With stickyMode low (0), pass after each clock edge is high exactly when the word sampled at that edge had no bit error.
- R6: With stickyMode high (1), the first errored word drives pass low. pass stays low for every later word, even error-free ones, while the enable stays high.
- R7: With loopEn high, rxDataOut equals txWord and the checker sees txWord, and txOutEn is low. With loopEn low, rxDataOut equals rxDataIn and txOutEn is high.
- R8: With the test enable low, pass is high and txWord equals txUserData. Lowering the enable for one clock edge clears a latched failure. It also re-seeds the generator to all ones.
- R9: Synchronous reset sets the generator to all ones and returns the checker to its unseeded state. If the enable is still high after reset, the pattern restarts at 0x040 and pass is low until the first word has been checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| testEn | input | 1 | Starts the generator and the checker |
| stickyMode | input | 1 | 0: transparent pass flag, 1: pass flag latches low on the first error |
| loopEn | input | 1 | Routes transmit words internally to the receiver |
| txUserData | input | 10 | User transmit word |
| txWord | output | 10 | Word sent to the serializer |
| txOutEn | output | 1 | External output enable; low during loopback |
| rxDataIn | input | 10 | Word from the deserializer |
| rxDataOut | output | 10 | Receive word seen by the checker and the user |
| pass | output | 1 | Check result, high when no error is seen |

## Verification
The hardest condition to reach from the ports is a single bit error at a chosen word and bit position. It has to land after the checker has seeded itself from the received stream. The bench turns loopback off and drives the receive port from its own model of the polynomial. It then flips chosen bits in one chosen word. Each vector names the mode, the word, the flip mask and the words after which pass must be low. The expectation covers the later word that is hit when a flipped bit feeds a prediction across the word boundary (flips at bit 3 or above). In sticky mode every word from the errored one onward must read low.

// File: rtl/prbs7_pkg.sv
`timescale 1ns/1ps
package prbs7_pkg;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic advance;     // step generator and checker by one word
    logic reseed;      // load all-ones into the generator
    logic clearFail;   // clear latched failure and result
    logic checkValid;  // checker history holds seven real bits
  } bistStrobes_t;

endpackage

// File: rtl/prbs7_ctrl.sv
`timescale 1ns/1ps
module prbs7_ctrl
  import prbs7_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         testEn,
  output bistStrobes_t strb
);

  logic seeded;

  // The checker counts as seeded once one word has gone by with the test on.
  always_ff @(posedge clk) begin
    if (rst) begin
      seeded <= 1'b0;
    end else begin
      seeded <= testEn;
    end
  end

  always_comb begin
    strb.advance    = testEn;
    strb.reseed     = ~testEn;
    strb.clearFail  = ~testEn;
    strb.checkValid = seeded;
  end

endmodule

// File: rtl/prbs7_datapath.sv
`timescale 1ns/1ps
module prbs7_datapath
  import prbs7_pkg::*;
#(
  parameter int WORD_W   = 10,
  parameter int LFSR_LEN = 7,
  parameter int TAP      = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  bistStrobes_t      strb,
  input  logic              testEn,
  input  logic              stickyMode,
  input  logic              loopEn,
  input  logic [WORD_W-1:0] txUserData,
  input  logic [WORD_W-1:0] rxDataIn,
  output logic [WORD_W-1:0] txWord,
  output logic [WORD_W-1:0] rxDataOut,
  output logic              txOutEn,
  output logic              pass
);

  localparam int EXT_W  = LFSR_LEN + WORD_W;
  localparam int FB_OFF = LFSR_LEN - TAP;

  // ---------------- generator ----------------
  logic [LFSR_LEN-1:0] genState;
  logic [LFSR_LEN-1:0] genNext;
  logic [WORD_W-1:0]   genWord;

  always_comb begin : genStep
    logic [LFSR_LEN-1:0] s;
    s = genState;
    for (int i = 0; i < WORD_W; i++) begin
      genWord[i] = s[LFSR_LEN-1] ^ s[TAP-1];
      s = {s[LFSR_LEN-2:0], genWord[i]};
    end
    genNext = s;
  end

  always_ff @(posedge clk) begin
    if (rst || strb.reseed) begin
      genState <= '1;
    end else if (strb.advance) begin
      genState <= genNext;
    end
  end

  assign txWord = testEn ? genWord : txUserData;

  // ---------------- loopback routing ----------------
  logic [WORD_W-1:0] rxSel;
  assign rxSel     = loopEn ? txWord : rxDataIn;
  assign rxDataOut = rxSel;
  assign txOutEn   = ~loopEn;

  // ---------------- checker ----------------
  // hist[0] is the oldest received bit, hist[LFSR_LEN-1] the newest.
  logic [LFSR_LEN-1:0] hist;
  logic [EXT_W-1:0]    ext;
  logic [WORD_W-1:0]   bitErr;
  logic                wordErr;

  assign ext = {rxSel, hist};

  for (genvar j = 0; j < WORD_W; j++) begin : g_bitCheck
    localparam bit IN_WORD_CHECK = (j >= LFSR_LEN);
    logic predicted;
    logic checkOn;
    assign predicted = ext[j] ^ ext[j + FB_OFF];
    if (IN_WORD_CHECK) begin : g_always
      assign checkOn = 1'b1;
    end else begin : g_afterSeed
      assign checkOn = strb.checkValid;
    end
    assign bitErr[j] = checkOn & (predicted ^ rxSel[j]);
  end

  assign wordErr = |bitErr;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
    end else if (strb.advance) begin
      hist <= rxSel[WORD_W-1 -: LFSR_LEN];
    end
  end

  // ---------------- result ----------------
  logic failLatched;
  logic resultReg;

  always_ff @(posedge clk) begin
    if (rst || strb.clearFail) begin
      failLatched <= 1'b0;
      resultReg   <= 1'b1;
    end else if (strb.advance) begin
      failLatched <= failLatched | wordErr;
      if (stickyMode) begin
        resultReg <= ~(failLatched | wordErr);
      end else begin
        resultReg <= ~wordErr;
      end
    end
  end

  assign pass = ~testEn | (strb.checkValid & resultReg);

endmodule

// File: rtl/prbs7_bist.sv
`timescale 1ns/1ps
module prbs7_bist
  import prbs7_pkg::*;
#(
  parameter int WORD_W   = 10,
  parameter int LFSR_LEN = 7,
  parameter int TAP      = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              testEn,
  input  logic              stickyMode,
  input  logic              loopEn,
  input  logic [WORD_W-1:0] txUserData,
  output logic [WORD_W-1:0] txWord,
  output logic              txOutEn,
  input  logic [WORD_W-1:0] rxDataIn,
  output logic [WORD_W-1:0] rxDataOut,
  output logic              pass
);

  bistStrobes_t strb;

  prbs7_ctrl i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .testEn (testEn),
    .strb   (strb)
  );

  prbs7_datapath #(
    .WORD_W  (WORD_W),
    .LFSR_LEN(LFSR_LEN),
    .TAP     (TAP)
  ) i_dp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .testEn     (testEn),
    .stickyMode (stickyMode),
    .loopEn     (loopEn),
    .txUserData (txUserData),
    .rxDataIn   (rxDataIn),
    .txWord     (txWord),
    .rxDataOut  (rxDataOut),
    .txOutEn    (txOutEn),
    .pass       (pass)
  );

endmodule

// File: rtl/prbs7_bist_sva.sv
`timescale 1ns/1ps
module prbs7_bist_sva #(
  parameter int WORD_W   = 10,
  parameter int LFSR_LEN = 7,
  parameter int TAP      = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              testEn,
  input logic              stickyMode,
  input logic              loopEn,
  input logic [WORD_W-1:0] txUserData,
  input logic [WORD_W-1:0] txWord,
  input logic              txOutEn,
  input logic [WORD_W-1:0] rxDataOut,
  input logic              pass
);

  // R1 / R2: first bit of a word follows from the previous word's bits.
  assert_word_chain_R1: assert property (@(posedge clk) disable iff (rst)
    (testEn && $past(testEn) && !$past(rst)) |->
      (txWord[0] == ($past(txWord[WORD_W-LFSR_LEN]) ^ $past(txWord[WORD_W-TAP]))))
    else $error("word chaining broken");

  // R6: a low flag in sticky mode stays low.
  assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (testEn && $past(testEn) && $past(testEn, 2) && !$past(rst) && !$past(rst, 2) &&
     stickyMode && $past(stickyMode) && !$past(pass)) |-> !pass)
    else $error("sticky failure released");

  // R7: loopback routes transmit to receive and drops the output enable.
  assert_loop_route_R7: assert property (@(posedge clk) disable iff (rst)
    loopEn |-> (rxDataOut == txWord && !txOutEn))
    else $error("loopback routing wrong");

  // R8: idle means pass high and user data through.
  assert_idle_pass_R8: assert property (@(posedge clk) disable iff (rst)
    !testEn |-> (pass && txWord == txUserData))
    else $error("idle behaviour wrong");

endmodule

bind prbs7_bist prbs7_bist_sva #(
  .WORD_W  (WORD_W),
  .LFSR_LEN(LFSR_LEN),
  .TAP     (TAP)
) i_sva (
  .clk        (clk),
  .rst        (rst),
  .testEn     (testEn),
  .stickyMode (stickyMode),
  .loopEn     (loopEn),
  .txUserData (txUserData),
  .txWord     (txWord),
  .txOutEn    (txOutEn),
  .rxDataOut  (rxDataOut),
  .pass       (pass)
);

// File: tb/test_prbs7_bist.sv
`timescale 1ns/1ps
module test_prbs7_bist;

  logic       clk = 1'b0;
  logic       rst;
  logic       testEn;
  logic       stickyMode;
  logic       loopEn;
  logic [9:0] txUserData;
  logic [9:0] txWord;
  logic       txOutEn;
  logic [9:0] rxDataIn;
  logic [9:0] rxDataOut;
  logic       pass;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  prbs7_bist i_prbs7_bist (
    .clk        (clk),
    .rst        (rst),
    .testEn     (testEn),
    .stickyMode (stickyMode),
    .loopEn     (loopEn),
    .txUserData (txUserData),
    .txWord     (txWord),
    .txOutEn    (txOutEn),
    .rxDataIn   (rxDataIn),
    .rxDataOut  (rxDataOut),
    .pass       (pass)
  );

  // Vector fields: {stickyMode, errWord[2:0], flipMask[9:0], lowAfterWord[7:0]}
  localparam int NVEC = 8;
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b0, 3'd0, 10'h000, 8'h00},
    {1'b0, 3'd2, 10'h001, 8'h04},
    {1'b0, 3'd3, 10'h020, 8'h18},
    {1'b0, 3'd0, 10'h100, 8'h03},
    {1'b0, 3'd6, 10'h003, 8'h40},
    {1'b1, 3'd2, 10'h001, 8'hFC},
    {1'b1, 3'd5, 10'h200, 8'hE0},
    {1'b1, 3'd0, 10'h080, 8'hFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  // Independent model of x^7 + x^6 + 1, bit 0 first.
  function automatic logic [16:0] modelStep(input logic [6:0] s);
    logic [9:0] w;
    for (int i = 0; i < 10; i++) begin
      w[i] = s[6] ^ s[5];
      s    = {s[5:0], w[i]};
    end
    return {s, w};
  endfunction

  initial begin
    #(20 * 100000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [6:0]  bState;
    logic [16:0] stepOut;
    int          lowCount;
    rst = 1'b1; testEn = 1'b0; stickyMode = 1'b0; loopEn = 1'b0;
    txUserData = 10'h2A5; rxDataIn = 10'h13C;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // reset / idle state
    chk("R9 pass after reset", pass, 1);
    chk("R8 idle passthrough", txWord, 10'h2A5);
    chk("R7 output enable idle", txOutEn, 1);
    chk("R7 rx passthrough", rxDataOut, 10'h13C);

    // generator words under loopback
    loopEn = 1'b1; testEn = 1'b1; txUserData = 10'h3FF;
    #1;
    chk("R1 first word", txWord, 10'h040);
    chk("R7 loop rx", rxDataOut, 10'h040);
    chk("R7 output enable loop", txOutEn, 0);
    chk("R4 pass before seeding", pass, 0);
    tick();
    chk("R1 second word", txWord, 10'h10C);
    chk("R4 pass after first word", pass, 1);
    lowCount = 0;
    for (int i = 2; i <= 127; i++) begin
      txUserData = 10'(i * 37);
      tick();
      if (!pass) lowCount++;
    end
    chk("R2 period 127", txWord, 10'h040);
    chk("R3 user data ignored", lowCount, 0);
    testEn = 1'b0; loopEn = 1'b0; txUserData = 10'h155;
    #1;
    chk("R8 pass idle", pass, 1);
    chk("R8 user data restored", txWord, 10'h155);
    tick();

    // table of error-injection vectors
    for (int v = 0; v < NVEC; v++) begin
      logic       vMode;
      logic [2:0] vWord;
      logic [9:0] vMask;
      logic [7:0] vLow;
      {vMode, vWord, vMask, vLow} = VEC[v];
      testEn = 1'b0;
      tick();
      stickyMode = vMode; testEn = 1'b1; bState = 7'h7F;
      for (int w = 0; w < 8; w++) begin
        stepOut  = modelStep(bState);
        bState   = stepOut[16:10];
        rxDataIn = stepOut[9:0] ^ ((w == vWord) ? vMask : 10'h000);
        if (w == 0) begin
          #1;
          chk("R4 unseeded pass", pass, 0);
        end
        tick();
        if (vMode) chk("R6 sticky pass", pass, !vLow[w]);
        else       chk("R5 transparent pass", pass, !vLow[w]);
      end
    end

    // clear of latched failure by dropping the enable
    testEn = 1'b0;
    #1;
    chk("R8 clear pass high", pass, 1);
    tick();
    testEn = 1'b1; bState = 7'h7F;
    for (int w = 0; w < 3; w++) begin
      stepOut  = modelStep(bState);
      bState   = stepOut[16:10];
      rxDataIn = stepOut[9:0];
      tick();
      chk("R8 sticky cleared", pass, 1);
    end

    // synchronous reset while testing
    testEn = 1'b0; tick();
    loopEn = 1'b1; testEn = 1'b1; stickyMode = 1'b0;
    repeat (5) tick();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    #1;
    chk("R9 restart word", txWord, 10'h040);
    chk("R9 unseeded after reset", pass, 0);
    tick();
    chk("R9 second word", txWord, 10'h10C);
    chk("R9 pass after reseed", pass, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule